// File: doc/BRIEF.md
# Extension-scoped CSR register bank

This block lives inside a composable extension unit and keeps a handful of control registers for every state context the unit supports. The host processor has already checked privilege. It forwards custom-range CSR instructions over the unit's request port. Each request names the selected state context and carries a function ID, the CSR address and a source operand. The block answers with the register's previous value and then updates the register according to the access kind.

The function ID is one bit wider than a plain custom function ID. When its top bit is clear, the request is an ordinary custom function. This block does not execute those: it answers "not handled" and changes nothing. When the top bit is set, the two low bits pick one of four CSR access kinds.

The registers sit at consecutive addresses from 0x800, in the user read-write custom range. Any other address gets an error status. The response is registered, and a ready/valid handshake runs on both the request side and the response side.

Top module: `xcsr_unit`

## Requirements
- R1: After synchronous reset, every register in every context reads as zero, `resp_valid` is low and `req_ready` is high.
- R2: A CSR access with `req_func[1:0]`=0 (read only) returns the addressed register and leaves it unchanged, whatever the operand on `req_data0`.
- R3: A CSR access with `req_func[1:0]`=1 (read-write) returns the old value and loads `req_data0` into the register.
- R4: A CSR access with `req_func[1:0]`=2 (read-set) returns the old value and ORs `req_data0` into the register.
- R5: A CSR access with `req_func[1:0]`=3 (read-clear) returns the old value and clears the register bits that are set in `req_data0`. A set or clear with a zero operand leaves the register unchanged.
- R6: Each of the NCTX contexts has a private copy of the registers. Only the context on `req_ctx` is read or written.
- R7: A CSR access whose address `req_data1[11:0]` lies outside 0x800..0x800+NREG-1 returns status 2 (function error) with zero data and changes no register. The upper bits of `req_data1` are ignored. A successful CSR access returns status 0.
- R8: A request with `req_func` MSB = 0 (custom function) returns status 3 (not handled) with zero data and changes no register.
- R9: The response is valid on the clock edge after the request is accepted. While `resp_ready` is low, the response holds steady and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_func | input | CF_ID_W+1 | MSB selects CSR access; for CSR access, bits [1:0] give the access kind |
| req_ctx | input | $clog2(NCTX) | Selected state context |
| req_data0 | input | DATA_W | Source operand / new value |
| req_data1 | input | DATA_W | Bits [11:0] carry the CSR address |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_status | output | 2 | 0 ok, 2 function error, 3 not handled |
| resp_data | output | DATA_W | Previous register value, or zero |

## Verification
The assertions assume that `req_ctx` stays below NCTX and that the request fields are stable while `req_valid` is high and `req_ready` is low. The bench only changes the request fields at falling edges, and only between accepted requests. Every context index it drives is legal. The backpressure case holds a response with `resp_ready` low for several cycles, and during that time no new request is offered.

// File: rtl/xcsr_pkg.sv
package xcsr_pkg;

    parameter int CF_ID_W    = 10;
    parameter int DATA_W     = 32;
    parameter int CSR_ADDR_W = 12;
    localparam int FID_W     = CF_ID_W + 1;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_RW   = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_RSVD      = 2'd1,
        ST_FUNC_ERR  = 2'd2,
        ST_UNHANDLED = 2'd3
    } status_e;

    typedef struct packed {
        logic    is_csr;
        csr_op_e op;
        logic    hit;
        logic    writes;
    } dec_s;

    function automatic logic [DATA_W-1:0] apply_op(
        input csr_op_e           op,
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] opnd
    );
        logic [DATA_W-1:0] nv;
        case (op)
            OP_RW:   nv = opnd;
            OP_SET:  nv = old_v | opnd;
            OP_CLR:  nv = old_v & ~opnd;
            default: nv = old_v;
        endcase
        return nv;
    endfunction

endpackage

// File: rtl/xcsr_decode.sv
module xcsr_decode
    import xcsr_pkg::*;
#(
    parameter int               NREG  = 4,
    parameter logic [11:0]      BASE  = 12'h800,
    localparam int              IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [FID_W-1:0]      func,
    input  logic [CSR_ADDR_W-1:0] addr,
    output dec_s                  dec,
    output logic [IDX_W-1:0]      idx
);

    logic [CSR_ADDR_W-1:0] offset;
    logic                  in_range;

    always_comb begin
        offset   = addr - BASE;
        in_range = (addr >= BASE) && ({20'd0, offset} < NREG);
        idx      = offset[IDX_W-1:0];

        dec.is_csr = func[FID_W-1];
        dec.op     = csr_op_e'(func[1:0]);
        dec.hit    = dec.is_csr && in_range;
        dec.writes = dec.hit && (dec.op != OP_READ);
    end

endmodule

// File: rtl/xcsr_store.sv
module xcsr_store
    import xcsr_pkg::*;
#(
    parameter int  NCTX  = 4,
    parameter int  NREG  = 4,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int ALL_W = NCTX * NREG * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [IDX_W-1:0]  idx,
    input  csr_op_e           op,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] rd_data,
    output logic [ALL_W-1:0]  all_regs
);

    always_comb begin
        rd_data = all_regs[(32'(ctx) * NREG + 32'(idx)) * DATA_W +: DATA_W];
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            logic [DATA_W-1:0] q;
            logic              sel;
            assign sel = wr_en && (32'(ctx) == c) && (32'(idx) == r);
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (sel) q <= apply_op(op, q, operand);
            end
            assign all_regs[(c * NREG + r) * DATA_W +: DATA_W] = q;
        end

        AST_CTX_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (32'(ctx) != c)) |=>
                $stable(all_regs[c * NREG * DATA_W +: NREG * DATA_W])); // R6
    end

endmodule

// File: rtl/xcsr_resp.sv
module xcsr_resp
    import xcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  status_e           st_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              resp_ready,
    output logic              resp_valid,
    output status_e           resp_status,
    output logic [DATA_W-1:0] resp_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_status <= ST_OK;
            resp_data   <= '0;
        end else if (accept) begin
            resp_valid  <= 1'b1;
            resp_status <= st_in;
            resp_data   <= data_in;
        end else if (resp_ready) begin
            resp_valid  <= 1'b0;
        end
    end

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=>
            (resp_valid && $stable(resp_data) && $stable(resp_status))); // R9

endmodule

// File: rtl/xcsr_unit.sv
module xcsr_unit
    import xcsr_pkg::*;
#(
    parameter int          NCTX  = 4,
    parameter int          NREG  = 4,
    parameter logic [11:0] BASE  = 12'h800,
    localparam int         IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int         CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FID_W-1:0]  req_func,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [DATA_W-1:0] req_data0,
    input  logic [DATA_W-1:0] req_data1,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [1:0]        resp_status,
    output logic [DATA_W-1:0] resp_data
);

    localparam int ALL_W = NCTX * NREG * DATA_W;

    dec_s                 dec;
    logic [IDX_W-1:0]     idx;
    logic                 accept;
    logic [DATA_W-1:0]    old_val;
    logic [ALL_W-1:0]     all_regs;
    status_e              st_next;
    status_e              st_q;
    logic [DATA_W-1:0]    data_next;

    assign req_ready = !resp_valid || resp_ready;
    assign accept    = req_valid && req_ready;

    xcsr_decode #(.NREG(NREG), .BASE(BASE)) u_dec (
        .func (req_func),
        .addr (req_data1[CSR_ADDR_W-1:0]),
        .dec  (dec),
        .idx  (idx)
    );

    xcsr_store #(.NCTX(NCTX), .NREG(NREG)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept && dec.writes),
        .ctx      (req_ctx),
        .idx      (idx),
        .op       (dec.op),
        .operand  (req_data0),
        .rd_data  (old_val),
        .all_regs (all_regs)
    );

    always_comb begin
        if (!dec.is_csr)   st_next = ST_UNHANDLED;
        else if (!dec.hit) st_next = ST_FUNC_ERR;
        else               st_next = ST_OK;
        data_next = dec.hit ? old_val : '0;
    end

    xcsr_resp u_resp (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .st_in       (st_next),
        .data_in     (data_next),
        .resp_ready  (resp_ready),
        .resp_valid  (resp_valid),
        .resp_status (st_q),
        .resp_data   (resp_data)
    );

    assign resp_status = st_q;

    AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> resp_valid); // R9

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |-> !req_ready); // R9

    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && (resp_status != 2'd0)) |-> (resp_data == '0)); // R7

    AST_NOWRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (accept && (!req_func[FID_W-1] || req_func[1:0] == 2'd0)) |=>
            $stable(all_regs)); // R2

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(all_regs)); // R8

endmodule

// File: tb/xcsr_unit_test.sv
module xcsr_unit_test;
    import xcsr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [10:0] req_func = '0;
    logic [1:0]  req_ctx = '0;
    logic [31:0] req_data0 = '0;
    logic [31:0] req_data1 = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b1;
    logic [1:0]  resp_status;
    logic [31:0] resp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    xcsr_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_func(req_func), .req_ctx(req_ctx), .req_data0(req_data0),
        .req_data1(req_data1), .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_status(resp_status), .resp_data(resp_data)
    );

    localparam int NV = 19;
    localparam logic [10:0] V_FUNC [NV] = '{
        11'h401, 11'h400, 11'h402, 11'h400, 11'h403, 11'h400, 11'h400,
        11'h401, 11'h400, 11'h401, 11'h400, 11'h005, 11'h400, 11'h402,
        11'h403, 11'h400, 11'h400, 11'h401, 11'h400};
    localparam logic [1:0] V_CTX [NV] = '{
        0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1, 1, 1, 0, 0, 0, 2, 3, 3};
    localparam logic [31:0] V_D0 [NV] = '{
        32'hA5A5_0000, 32'hFFFF_FFFF, 32'h0000_00FF, 32'h0, 32'hA000_0000,
        32'h0, 32'h0, 32'h1234_5678, 32'h0, 32'hFFFF_FFFF, 32'h0,
        32'h0000_00FF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hCAFE_F00D, 32'h0};
    localparam logic [31:0] V_D1 [NV] = '{
        32'h800, 32'h800, 32'h800, 32'h800, 32'h800, 32'h800, 32'h800,
        32'h803, 32'h803, 32'h804, 32'h803, 32'h803, 32'h803, 32'h800,
        32'h800, 32'h800, 32'h7FF, 32'h801, 32'hFFFF_F801};
    localparam logic [1:0] V_ST [NV] = '{
        0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 3, 0, 0, 0, 0, 2, 0, 0};
    localparam logic [31:0] V_DATA [NV] = '{
        32'h0, 32'hA5A5_0000, 32'hA5A5_0000, 32'hA5A5_00FF, 32'hA5A5_00FF,
        32'h05A5_00FF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1234_5678, 32'h0,
        32'h1234_5678, 32'h05A5_00FF, 32'h05A5_00FF, 32'h05A5_00FF, 32'h0,
        32'h0, 32'hCAFE_F00D};
    localparam string V_TAG [NV] = '{
        "R3", "R2", "R4", "R4", "R5", "R5", "R6", "R3", "R6", "R7",
        "R7", "R8", "R8", "R5", "R5", "R5", "R7", "R3", "R7"};

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [10:0] f, input logic [1:0] c,
                         input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        req_func  = f;
        req_ctx   = c;
        req_data0 = d0;
        req_data1 = d1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
        check("R1 req_ready", {31'd0, req_ready}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            issue(V_FUNC[i], V_CTX[i], V_D0[i], V_D1[i]);
            check({V_TAG[i], " valid"}, {31'd0, resp_valid}, 32'd1);
            check({V_TAG[i], " status"}, {30'd0, resp_status}, {30'd0, V_ST[i]});
            check({V_TAG[i], " data"}, resp_data, V_DATA[i]);
        end

        // R9: backpressure holds the response and blocks requests
        @(negedge clk);
        resp_ready = 1'b0;
        issue(11'h400, 2'd3, 32'h0, 32'h801);
        check("R9 valid first", {31'd0, resp_valid}, 32'd1);
        check("R9 ready low", {31'd0, req_ready}, 32'd0);
        repeat (3) @(negedge clk);
        check("R9 held valid", {31'd0, resp_valid}, 32'd1);
        check("R9 held data", resp_data, 32'hCAFE_F00D);
        resp_ready = 1'b1;
        @(negedge clk);
        check("R9 released", {31'd0, resp_valid}, 32'd0);

        // R1: reset clears every context
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(11'h400, 2'd0, 32'h0, 32'h800);
        check("R1 ctx0 cleared", resp_data, 32'h0);
        issue(11'h400, 2'd3, 32'h0, 32'h801);
        check("R1 ctx3 cleared", resp_data, 32'h0);
        issue(11'h400, 2'd1, 32'h0, 32'h803);
        check("R1 ctx1 cleared", resp_data, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule